// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A packed configuration word carries two divide settings and a select bit that picks between them. One setting is a linear field that gives an even ratio. The other is an exponent that gives a power-of-two ratio. Next to the serial clock, the block drives two single-cycle strobes. They mark the cycle in which the clock leaves its idle level and the cycle in which it returns. A neighbouring shift engine uses these strobes to launch and capture bits, so it never has to detect edges on the divided clock.

The block has no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. The divider starts when `run_en` is seen high while it is idle. At that start it captures the configuration word and the idle polarity. Any later change to either waits until the divider is idle again. When `run_en` is dropped, the current half period that is away from the idle level runs to its end, and then the clock parks.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sclk`, `lead_stb` and `trail_stb` are 0.
- R2: When bit 12 of `cfg_word` is 1, the serial clock period is 2 × (L + 1) module clocks, where L is `cfg_word[7:0]` (L = 0 gives 2, L = 255 gives 512).
- R3: When bit 12 of `cfg_word` is 0 and E = `cfg_word[11:8]` is 1 or more, the serial clock period is 2^E module clocks.
- R4: An exponent of 0 is clamped to the smallest achievable ratio, a period of 2 module clocks.
- R5: While idle, `sclk` equals the `idle_pol` value sampled at the previous clock edge.
- R6: A start happens at the first edge where `run_en` is high and the divider is idle. `sclk` first leaves the idle level exactly H edges later, with H being half the period, so the first half period has full length.
- R7: `lead_stb` is high for exactly the one cycle in which `sclk` first shows the non-idle level, and `trail_stb` is high for the one cycle in which it first shows the idle level again. The two are never high together, so every period carries one of each.
- R8: Changes to `cfg_word` or `idle_pol` while running have no effect on period or levels until the divider has returned to idle.
- R9: When `run_en` is low during a non-idle half period, that half period completes, then `trail_stb` pulses and `sclk` stays at the idle level with no further `lead_stb`. When `run_en` is low during an idle-level half period, the divider stops at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 13 | [7:0] linear field, [11:8] exponent, [12] mode select (1 = linear) |
| run_en | input | 1 | Run request, level sensitive |
| idle_pol | input | 1 | Level `sclk` holds when idle |
| sclk | output | 1 | Divided serial clock |
| lead_stb | output | 1 | One-cycle pulse as `sclk` leaves the idle level |
| trail_stb | output | 1 | One-cycle pulse as `sclk` returns to the idle level |

## Verification
The checker watches every cycle to confirm four things. The strobes are mutually exclusive and appear only in cycles where `sclk` actually changed. An idle divider tracks the sampled polarity. The captured divide setting stays stable for as long as the divider runs. The cycle-accurate reference model in the bench covers what a simple property cannot: the exact period in each mode and at the field extremes, the length of the first half period, settings ignored in mid-run, and the graceful completion of a stop.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_strobe_t;

endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int TW    = 14
) (
  input  logic [LIN_W+EXP_W:0] cfg_word,
  output logic [TW-1:0]        term
);

  localparam int LIN_LSB = 0;
  localparam int EXP_LSB = LIN_W;
  localparam int SEL_BIT = LIN_W + EXP_W;
  localparam int EXP_MAX = (2 ** EXP_W) - 1;

  logic [LIN_W-1:0] lin_f;
  logic [EXP_W-1:0] exp_f;
  logic             lin_mode;
  logic [TW-1:0]    lin_term;
  logic [TW-1:0]    exp_term;

  assign lin_f    = cfg_word[LIN_LSB +: LIN_W];
  assign exp_f    = cfg_word[EXP_LSB +: EXP_W];
  assign lin_mode = cfg_word[SEL_BIT];

  // the linear half period is field + 1 cycles, so the terminal count is the field
  assign lin_term = TW'(lin_f);

  // half period of 2^(e-1) cycles; e = 0 clamps to the 1-cycle half period
  always_comb begin
    exp_term = '0;
    for (int i = 1; i <= EXP_MAX; i++) begin
      if (int'(exp_f) == i) exp_term = TW'((1 << (i - 1)) - 1);
    end
  end

  assign term = lin_mode ? lin_term : exp_term;

endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
  parameter int TW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [TW-1:0] term_d,
  output logic [TW-1:0] term_q,
  output logic          wrap
);

  logic [TW-1:0] cnt_q;

  assign wrap = step && (cnt_q == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (start) begin
      cnt_q  <= '0;
      term_q <= term_d;
    end else if (step) begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_phase_ctl.sv
module sclk_phase_ctl
  import spi_clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic idle_pol,
  input  logic wrap,
  output logic start,
  output logic step,
  output logic busy,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);

  div_state_e   state_q;
  logic         phase_q;
  logic         pol_q;
  edge_strobe_t stb_q;
  logic         stop;

  assign start = (state_q == DIV_IDLE) && run_en;
  assign stop  = (state_q == DIV_RUN) && !run_en && !phase_q;
  assign step  = (state_q == DIV_RUN) && !stop;
  assign busy  = (state_q == DIV_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      phase_q <= 1'b0;
      pol_q   <= 1'b0;
      stb_q   <= '0;
    end else begin
      stb_q <= '0;
      unique case (state_q)
        DIV_IDLE: begin
          pol_q   <= idle_pol;
          phase_q <= 1'b0;
          if (run_en) state_q <= DIV_RUN;
        end
        DIV_RUN: begin
          if (stop) begin
            state_q <= DIV_IDLE;
          end else if (wrap) begin
            phase_q     <= ~phase_q;
            stb_q.lead  <= ~phase_q;
            stb_q.trail <= phase_q;
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign sclk      = phase_q ^ pol_q;
  assign lead_stb  = stb_q.lead;
  assign trail_stb = stb_q.trail;

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LIN_W+EXP_W:0] cfg_word,
  input  logic                 run_en,
  input  logic                 idle_pol,
  output logic                 sclk,
  output logic                 lead_stb,
  output logic                 trail_stb
);

  localparam int EXP_TW = (2 ** EXP_W) - 2;
  localparam int TW     = (LIN_W > EXP_TW) ? LIN_W : EXP_TW;

  logic [TW-1:0] term_d;
  logic [TW-1:0] term_q;
  logic          start;
  logic          step;
  logic          wrap;
  logic          busy;

  sclk_cfg_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .TW(TW)) u_dec (
    .cfg_word (cfg_word),
    .term     (term_d)
  );

  sclk_half_counter #(.TW(TW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .step   (step),
    .term_d (term_d),
    .term_q (term_q),
    .wrap   (wrap)
  );

  sclk_phase_ctl u_ph (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .idle_pol  (idle_pol),
    .wrap      (wrap),
    .start     (start),
    .step      (step),
    .busy      (busy),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

endmodule

// File: rtl/sclk_div_checker.sv
module sclk_div_checker #(
  parameter int TW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_pol,
  input logic          sclk,
  input logic          lead_stb,
  input logic          trail_stb,
  input logic          busy,
  input logic [TW-1:0] term_q
);

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R7
  lead_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != $past(sclk)));

  // R7
  trail_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk != $past(sclk)));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (sclk == $past(idle_pol)));

  // R8
  setting_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(term_q));

  // R9
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !(lead_stb || trail_stb));

endmodule

bind spi_sclk_divider sclk_div_checker #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idle_pol  (idle_pol),
  .sclk      (sclk),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .busy      (busy),
  .term_q    (term_q)
);

// File: tb/sim_spi_sclk_divider.sv
module sim_spi_sclk_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        run_en = 1'b0;
  logic        idle_pol = 1'b0;
  logic        sclk, lead_stb, trail_stb;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string tag = "R1";

  // reference model state
  bit m_act, m_ph, m_pol, m_lead, m_trail;
  int m_cnt, m_term;
  int last_lead_cyc = 0;
  int last_per = 0;
  int lead_cnt = 0;
  int trail_cnt = 0;

  spi_sclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .run_en(run_en),
    .idle_pol(idle_pol), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int term_of(logic [12:0] w);
    int e;
    if (w[12]) return int'(w[7:0]);
    e = int'(w[11:8]);
    if (e == 0) return 0;
    return (1 << (e - 1)) - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_pol = 0; m_lead = 0; m_trail = 0; m_cnt = 0; m_term = 0;
    end else begin
      m_lead = 0; m_trail = 0;
      if (!m_act) begin
        m_pol = idle_pol;
        m_ph  = 0;
        if (run_en) begin
          m_act = 1; m_cnt = 0; m_term = term_of(cfg_word);
        end
      end else if (!run_en && !m_ph) begin
        m_act = 0;
      end else if (m_cnt == m_term) begin
        m_cnt = 0;
        m_ph  = !m_ph;
        if (m_ph) m_lead = 1; else m_trail = 1;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(sclk == (m_ph ^ m_pol), tag, sclk, m_ph ^ m_pol, "sclk vs model");
      check(lead_stb == m_lead, tag, lead_stb, m_lead, "lead_stb vs model");
      check(trail_stb == m_trail, tag, trail_stb, m_trail, "trail_stb vs model");
      if (lead_stb) begin
        last_per = cyc - last_lead_cyc;
        last_lead_cyc = cyc;
        lead_cnt++;
      end
      if (trail_stb) trail_cnt++;
    end
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [12:0] mk(bit sel, int e, int l);
    return {sel, 4'(e), 8'(l)};
  endfunction

  // starts, checks first half length (R6), runs, checks period
  task automatic run_mode(logic [12:0] w, bit pol, int exp_per, string req);
    int n;
    tag = req;
    cfg_word = w; idle_pol = pol;
    tick(2);
    check(sclk == pol, "R5", sclk, pol, "idle level before start");
    run_en = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!lead_stb && n < 2000);
    check(n == exp_per/2 + 1, "R6", n, exp_per/2 + 1, "edges to first lead");
    tick(3 * exp_per);
    check(last_per == exp_per, req, last_per, exp_per, "period");
    run_en = 1'b0;
    tick(exp_per + 4);
    check(sclk == pol, "R9", sclk, pol, "parked level after stop");
  endtask

  initial begin
    tick(3);
    check(sclk == 0 && lead_stb == 0 && trail_stb == 0, "R1", {sclk, lead_stb, trail_stb}, 0, "outputs in reset");
    rst_n = 1'b1;
    tick();
    check(sclk == 0 && lead_stb == 0 && trail_stb == 0, "R1", {sclk, lead_stb, trail_stb}, 0, "outputs after reset");

    run_mode(mk(1, 9, 2),   1'b0, 6,   "R2");
    run_mode(mk(1, 0, 0),   1'b1, 2,   "R2");
    run_mode(mk(1, 1, 255), 1'b0, 512, "R2");
    run_mode(mk(0, 3, 77),  1'b1, 8,   "R3");
    run_mode(mk(0, 1, 5),   1'b0, 2,   "R3");
    run_mode(mk(0, 6, 0),   1'b0, 64,  "R3");
    run_mode(mk(0, 0, 200), 1'b0, 2,   "R4");

    // R8: settings change mid-run are ignored
    tag = "R8";
    cfg_word = mk(1, 0, 1); idle_pol = 1'b0;
    tick(2);
    run_en = 1'b1;
    tick(10);
    cfg_word = mk(1, 0, 5); idle_pol = 1'b1;
    tick(20);
    check(last_per == 4, "R8", last_per, 4, "period after mid-run change");
    run_en = 1'b0;
    tick(8);
    check(sclk == 1'b1, "R8", sclk, 1, "new polarity applied once idle");

    // R9: stop during the non-idle half period
    tag = "R9";
    cfg_word = mk(1, 0, 3); idle_pol = 1'b0;
    tick(2);
    run_en = 1'b1;
    do tick(); while (!lead_stb);
    tick(1);
    lead_cnt = 0; trail_cnt = 0;
    run_en = 1'b0;
    tick(30);
    check(trail_cnt == 1, "R9", trail_cnt, 1, "trail pulses after stop");
    check(lead_cnt == 0, "R9", lead_cnt, 0, "lead pulses after stop");
    check(sclk == 1'b0, "R9", sclk, 0, "idle level after stop");

    // R7: leads and trails balance over a run
    tag = "R7";
    cfg_word = mk(0, 2, 0);
    tick(2);
    lead_cnt = 0; trail_cnt = 0;
    run_en = 1'b1;
    tick(41);
    run_en = 1'b0;
    tick(10);
    check(lead_cnt == trail_cnt, "R7", lead_cnt, trail_cnt, "lead vs trail count");
    check(lead_cnt == 10, "R7", lead_cnt, 10, "periods in 41 running cycles");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule